// File: doc/BRIEF.md
# Port Register with Power-Mode Controls

An eight-bit general-purpose port with a data register, a direction (configuration) register and a synchronized pin-read path. Pins 0 to 5 are ordinary bidirectional I/O. Pin 6 can only be an input, and pin 7 is permanently given to the oscillator clock output. Because those two pins cannot use all of their register bits, the spare bits take on control roles. Writing the upper two data bits requests the two low-power modes, and configuration bit 6 selects the alternate phase of the serial shift clock.

The block drives the pad output and enable lines. It gives the power sequencer one-cycle request pulses and gives the serial engine the phase level. It also connects the pins to the interrupt, timer and serial peripherals. When a peripheral enables its output, that peripheral drives the shared pin in place of the port register. The peripherals' input pins are passed on through the same synchronizer that the read path uses.

Top module: `gpio_pwr_port`

## Requirements
- R1: Reset clears both registers. After reset, pad_oe[5:0] is 0, halt_req and idle_req are 0, sk_alt_phase is 0, and reads of the data and configuration registers return 0.
- R2: For pins 0 to 5, with no peripheral override, pad_oe[i] equals configuration bit i and pad_out[i] equals data bit i, from the cycle after the write.
- R3: Reads use rd_sel = 0 for the data register, 1 for the configuration register, 2 for the pins and 3 for nothing (returns 0). A data read returns bits 5:0 as last written and bits 7:6 as 0. A configuration read returns bits 6:0 as last written and bit 7 as 0.
- R4: A data write (wr_sel = 0) with wr_data[7] = 1 makes halt_req 1 for exactly the cycle after the write edge. Configuration writes never pulse it.
- R5: A data write with wr_data[6] = 1 makes idle_req 1 for exactly the cycle after the write edge. Configuration writes never pulse it.
- R6: sk_alt_phase holds configuration bit 6 (wr_sel = 1) from the cycle after the write.
- R7: pad_oe[6] is always 0. pad_oe[7] is always 1, and pad_out[7] always equals osc_clk.
- R8: A pin read returns each pad level from bits 6:0 after two clock edges, with bit 7 read as 0. The value from one edge after the change is still the previous level.
- R9: tmr_io_oe, sio_so_oe and sio_sk_oe each force the output enable of pin 3, 4 and 5 respectively, and that pin then drives tmr_io_out, sio_so or sio_sk_out, whatever the port registers hold.
- R10: ext_int, tmr_cap, tmr_io_in, sio_sk_in and sio_si give the synchronized levels of pins 0, 2, 3, 5 and 6, with the same two-edge latency as the pin read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects data, 1 selects configuration |
| wr_data | input | 8 | Write value |
| rd_sel | input | 2 | Read source select |
| rd_data | output | 8 | Read value (combinational) |
| osc_clk | input | 1 | Oscillator clock forwarded to pin 7 |
| pad_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables |
| halt_req | output | 1 | One-cycle HALT request |
| idle_req | output | 1 | One-cycle IDLE request |
| sk_alt_phase | output | 1 | Alternate serial clock phase select |
| tmr_io_oe | input | 1 | Timer drives pin 3 |
| tmr_io_out | input | 1 | Timer output value |
| sio_so_oe | input | 1 | Serial engine drives pin 4 |
| sio_so | input | 1 | Serial data out |
| sio_sk_oe | input | 1 | Serial engine drives pin 5 |
| sio_sk_out | input | 1 | Serial clock out |
| ext_int | output | 1 | Synchronized pin 0 |
| tmr_cap | output | 1 | Synchronized pin 2 |
| tmr_io_in | output | 1 | Synchronized pin 3 |
| sio_sk_in | output | 1 | Synchronized pin 5 |
| sio_si | output | 1 | Synchronized pin 6 |

## Verification
Register effects appear one edge after a write. The pad lines, the phase select, the register reads and the mode pulses are therefore sampled on the falling edge that follows the write edge, and the pulses are sampled again one cycle later to confirm they have dropped. Pin levels take two edges, so the bench applies each pad pattern on a falling edge and samples after one edge (old value expected) and after two (new value expected). Peripheral overrides and the forwarded clock are combinational and are sampled in the same half-cycle in which they are driven.

// File: rtl/gpio_pwr_port.sv
module gpio_pwr_port #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [7:0] wr_data,
  input  logic [1:0] rd_sel,
  output logic [7:0] rd_data,
  input  logic       osc_clk,
  input  logic [7:0] pad_in,
  output logic [7:0] pad_out,
  output logic [7:0] pad_oe,
  output logic       halt_req,
  output logic       idle_req,
  output logic       sk_alt_phase,
  input  logic       tmr_io_oe,
  input  logic       tmr_io_out,
  input  logic       sio_so_oe,
  input  logic       sio_so,
  input  logic       sio_sk_oe,
  input  logic       sio_sk_out,
  output logic       ext_int,
  output logic       tmr_cap,
  output logic       tmr_io_in,
  output logic       sio_sk_in,
  output logic       sio_si
);
  localparam int HALT_BIT = 7;
  localparam int IDLE_BIT = 6;
  localparam int PHASE_BIT = 6;
  localparam int IO_W = 6;

  logic [IO_W-1:0] dat_q, cfg_q;
  logic            phase_q, halt_q, idle_q;
  logic [7:0]      sync_q [SYNC_STAGES];
  logic [7:0]      pin_lvl;
  logic            wr_dat, wr_cfg;

  assign wr_dat = wr_en & ~wr_sel;
  assign wr_cfg = wr_en & wr_sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dat_q   <= '0;
      cfg_q   <= '0;
      phase_q <= 1'b0;
      halt_q  <= 1'b0;
      idle_q  <= 1'b0;
    end else begin
      if (wr_dat) dat_q <= wr_data[IO_W-1:0];
      if (wr_cfg) begin
        cfg_q   <= wr_data[IO_W-1:0];
        phase_q <= wr_data[PHASE_BIT];
      end
      halt_q <= wr_dat & wr_data[HALT_BIT];
      idle_q <= wr_dat & wr_data[IDLE_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SYNC_STAGES; s++) sync_q[s] <= '0;
    end else begin
      sync_q[0] <= pad_in;
      for (int s = 1; s < SYNC_STAGES; s++) sync_q[s] <= sync_q[s-1];
    end
  end

  assign pin_lvl = {1'b0, sync_q[SYNC_STAGES-1][6:0]};

  always_comb begin
    pad_out = {osc_clk, 1'b0, dat_q};
    pad_oe  = {1'b1, 1'b0, cfg_q};
    if (tmr_io_oe) begin pad_out[3] = tmr_io_out; pad_oe[3] = 1'b1; end
    if (sio_so_oe) begin pad_out[4] = sio_so;     pad_oe[4] = 1'b1; end
    if (sio_sk_oe) begin pad_out[5] = sio_sk_out; pad_oe[5] = 1'b1; end
  end

  always_comb begin
    case (rd_sel)
      2'd0:    rd_data = {2'b00, dat_q};
      2'd1:    rd_data = {1'b0, phase_q, cfg_q};
      2'd2:    rd_data = pin_lvl;
      default: rd_data = '0;
    endcase
  end

  assign halt_req     = halt_q;
  assign idle_req     = idle_q;
  assign sk_alt_phase = phase_q;
  assign ext_int      = pin_lvl[0];
  assign tmr_cap      = pin_lvl[2];
  assign tmr_io_in    = pin_lvl[3];
  assign sio_sk_in    = pin_lvl[5];
  assign sio_si       = pin_lvl[6];
endmodule

// File: rtl/gpio_pwr_port_chk.sv
module gpio_pwr_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       wr_sel,
  input logic [7:0] wr_data,
  input logic [1:0] rd_sel,
  input logic [7:0] rd_data,
  input logic [7:0] pad_oe,
  input logic       halt_req,
  input logic       idle_req,
  input logic       sk_alt_phase,
  input logic       tmr_io_oe,
  input logic       sio_so_oe,
  input logic       sio_sk_oe
);
  AST_HALT_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel && wr_data[7]) |=> halt_req); // R4
  AST_HALT_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && !wr_sel && wr_data[7]) |=> !halt_req); // R4
  AST_IDLE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel && wr_data[6]) |=> idle_req); // R5
  AST_IDLE_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && !wr_sel && wr_data[6]) |=> !idle_req); // R5
  AST_PHASE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel) |=> (sk_alt_phase == $past(wr_data[6]))); // R6
  AST_PHASE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_sel) |=> $stable(sk_alt_phase)); // R6
  AST_DIR_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel && !tmr_io_oe && !sio_so_oe && !sio_sk_oe) ##1
    (!tmr_io_oe && !sio_so_oe && !sio_sk_oe) |-> (pad_oe[5:0] == $past(wr_data[5:0]))); // R2
  AST_FIXED_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    pad_oe[7] && !pad_oe[6]); // R7
  AST_DATA_READ_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel == 2'd0) |-> (rd_data[7:6] == 2'b00)); // R3
endmodule

bind gpio_pwr_port gpio_pwr_port_chk u_chk (.*);

// File: tb/gpio_pwr_port_tb.sv
module gpio_pwr_port_tb;
  localparam int PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, wr_sel = 0;
  logic [7:0] wr_data = 0;
  logic [1:0] rd_sel = 0;
  logic [7:0] rd_data;
  logic osc_clk = 0;
  logic [7:0] pad_in = 0, pad_out, pad_oe;
  logic halt_req, idle_req, sk_alt_phase;
  logic tmr_io_oe = 0, tmr_io_out = 0, sio_so_oe = 0, sio_so = 0, sio_sk_oe = 0, sio_sk_out = 0;
  logic ext_int, tmr_cap, tmr_io_in, sio_sk_in, sio_si;
  int errors = 0, checks = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;
  always #3 osc_clk = ~osc_clk;

  gpio_pwr_port u_dut (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] v);
    rd_sel = s; #1; v = rd_data;
  endtask

  initial begin
    #(PERIOD*200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [7:0] prev;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 oe", {2'b0, pad_oe[5:0]}, 8'h00);
    chk("R1 halt/idle/phase", {5'b0, halt_req, idle_req, sk_alt_phase}, 8'h00);
    rd(0, v); chk("R1 data read", v, 8'h00);
    rd(1, v); chk("R1 cfg read", v, 8'h00);

    // Sweep all configuration values with a derived data value
    for (int c = 0; c < 256; c++) begin
      logic [7:0] d;
      d = 8'(c) ^ 8'h3C;
      wr(1, 8'(c));
      chk("R4 no halt on cfg write", {7'b0, halt_req}, 8'h00);
      chk("R5 no idle on cfg write", {7'b0, idle_req}, 8'h00);
      chk("R6 phase", {7'b0, sk_alt_phase}, {7'b0, c[6]});
      rd(1, v); chk("R3 cfg read", v, {1'b0, c[6:0]});
      wr(0, d);
      chk("R4 halt pulse", {7'b0, halt_req}, {7'b0, d[7]});
      chk("R5 idle pulse", {7'b0, idle_req}, {7'b0, d[6]});
      chk("R2 oe", {2'b0, pad_oe[5:0]}, {2'b0, c[5:0]});
      chk("R2 out", {2'b0, pad_out[5:0]}, {2'b0, d[5:0]});
      chk("R7 fixed pins", {6'b0, pad_oe[7:6]}, 8'h02);
      chk("R7 clock fwd", {7'b0, pad_out[7]}, {7'b0, osc_clk});
      rd(0, v); chk("R3 data read", v, {2'b0, d[5:0]});
      rd(3, v); chk("R3 unused select", v, 8'h00);
      @(negedge clk);
      chk("R4 halt single cycle", {7'b0, halt_req}, 8'h00);
      chk("R5 idle single cycle", {7'b0, idle_req}, 8'h00);
    end

    // Peripheral overrides with port registers in opposite state
    for (int m = 0; m < 64; m++) begin
      logic [5:0] mm;
      mm = 6'(m);
      wr(1, {2'b00, {6{mm[0]}}});
      wr(0, {2'b00, {6{mm[1]}}});
      tmr_io_oe = mm[2]; sio_so_oe = mm[3]; sio_sk_oe = mm[4];
      tmr_io_out = mm[5]; sio_so = ~mm[5]; sio_sk_out = mm[5];
      #1;
      chk("R9 pin3 oe", {7'b0, pad_oe[3]}, {7'b0, mm[2] | mm[0]});
      chk("R9 pin4 oe", {7'b0, pad_oe[4]}, {7'b0, mm[3] | mm[0]});
      chk("R9 pin5 oe", {7'b0, pad_oe[5]}, {7'b0, mm[4] | mm[0]});
      chk("R9 pin3 out", {7'b0, pad_out[3]}, {7'b0, mm[2] ? mm[5] : mm[1]});
      chk("R9 pin4 out", {7'b0, pad_out[4]}, {7'b0, mm[3] ? ~mm[5] : mm[1]});
      chk("R9 pin5 out", {7'b0, pad_out[5]}, {7'b0, mm[4] ? mm[5] : mm[1]});
      chk("R9 pin0 unaffected", {7'b0, pad_out[0]}, {7'b0, mm[1]});
      @(negedge clk);
      tmr_io_oe = 0; sio_so_oe = 0; sio_sk_oe = 0;
    end

    // Pin-read sweep with two-edge latency
    prev = pad_in;
    @(negedge clk);
    for (int p = 0; p < 256; p++) begin
      logic [7:0] nv;
      nv = 8'(p) ^ 8'hA5;
      pad_in = nv;
      @(negedge clk);
      rd(2, v); chk("R8 one edge old", v, {1'b0, prev[6:0]});
      @(negedge clk);
      rd(2, v); chk("R8 two edges new", v, {1'b0, nv[6:0]});
      chk("R10 alt inputs", {3'b0, ext_int, tmr_cap, tmr_io_in, sio_sk_in, sio_si},
          {3'b0, nv[0], nv[2], nv[3], nv[5], nv[6]});
      prev = nv;
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule